// File: doc/BRIEF.md
# Node-Array Genome Evaluator

This block scores a candidate combinational circuit that is described by a stored genome. The genome encodes a feed-forward row of programmable nodes. Each node has three operand genes and one operation gene, and a tail of output genes names which signals drive the circuit outputs. Software or a search engine writes the genome and a reference truth table through a small write port. It then pulses a start input. The block answers with the number of output bits that differ from the reference, taken over every possible input vector.

Evaluation is bit-parallel. Each of the 2^NUM_IN input vectors has its own bit lane, so one node is computed for all vectors in a single clock cycle. Nodes are computed in index order, and a final cycle compares the selected outputs against the reference. A gene that names a signal which is not yet computed, that names a signal which does not exist, or that holds an undefined operation code marks the result invalid.

Top module: `cgp_chrom_sim`

## Requirements
- R1: While reset is asserted and right after it is released, busy, done, valid and err_count are all 0, and the stored genome and reference words are all 0.
- R2: A write with gene_we stores gene_wdata at genome word gene_addr. For node k, word 4k+0, 4k+1 and 4k+2 are the first, second and third operand genes, and word 4k+3 is the operation gene. Word 4*NUM_NODE+o is the output gene of output o. A write with ref_we stores ref_wdata as the reference of output ref_sel. Writes of either kind made while busy is 1 are ignored.
- R3: A start seen while idle makes busy 1 for exactly NUM_NODE+1 cycles. A start seen while busy has no effect. done is 1 for exactly one cycle, in the first cycle that busy is 0 again.
- R4: Signal numbers 0 to NUM_IN-1 are the primary inputs, and signal NUM_IN+k is the output of node k. In input vector v, primary input i takes bit i of v.
- R5: Operation code 0 is OR, 1 is AND and 2 is XOR of the first two operands; the third operand does not affect these. Code 3 is a multiplexer that yields the second operand when the third operand is 1 and the first operand otherwise.
- R6: When done is 1, err_count equals the number of pairs (output o, vector v) in which the produced output differs from bit v of the reference word of output o.
- R7: An output gene may name any signal below NUM_IN+NUM_NODE. A larger value makes valid 0, and that output is taken as 0 in every vector.
- R8: An operand gene of node k that is not below NUM_IN+k reads as 0, and an operation code above 3 makes the node output 0. Either case makes valid 0, even for a node that no output uses.
- R9: err_count and valid change only in a cycle in which done is 1, and they hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gene_we | input | 1 | Genome word write strobe |
| gene_addr | input | AW | Genome word index |
| gene_wdata | input | GW | Genome word value |
| ref_we | input | 1 | Reference word write strobe |
| ref_sel | input | OW | Output whose reference is written |
| ref_wdata | input | NV | Reference bits, bit v for input vector v |
| start | input | 1 | Begin an evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Last genome was free of illegal genes |
| err_count | output | EW | Mismatching output bits of the last evaluation |

## Verification
On every cycle the bound assertions check the handshake timing: the done pulse lasts one cycle and coincides with the fall of busy, busy stays high for NUM_NODE+1 cycles, an accepted start raises busy, and the result registers hold between pulses while the count stays within its bound. Whether the count is right for a given genome can only be shown by the bench's scenarios. These scenarios drive the bench's reference evaluation against the full-adder genome, the multiplexer select polarity, boundary and forward operand genes, undefined operation codes, out-of-range output genes, writes made while busy, and a run of random genomes.

// File: rtl/cgp_pkg.sv
package cgp_pkg;

  typedef enum logic [1:0] {
    FN_OR  = 2'd0,
    FN_AND = 2'd1,
    FN_XOR = 2'd2,
    FN_MUX = 2'd3
  } node_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NODE = 2'd1,
    ST_FIN  = 2'd2
  } eval_state_e;

endpackage

// File: rtl/cgp_gene_store.sv
module cgp_gene_store #(
  parameter int NUM_NODE = 8,
  parameter int NUM_OUT  = 2,
  parameter int NV       = 8,
  parameter int GW       = 4,
  parameter int AW       = 6,
  parameter int OW       = 1,
  parameter int NW       = 3,
  localparam int GLEN    = 4 * NUM_NODE + NUM_OUT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         gene_we,
  input  logic [AW-1:0]                gene_addr,
  input  logic [GW-1:0]                gene_wdata,
  input  logic                         ref_we,
  input  logic [OW-1:0]                ref_sel,
  input  logic [NV-1:0]                ref_wdata,
  input  logic [NW-1:0]                node_sel,
  output logic [3:0][GW-1:0]           node_genes,
  output logic [NUM_OUT-1:0][GW-1:0]   out_genes,
  output logic [NUM_OUT-1:0][NV-1:0]   ref_words
);

  logic [GLEN-1:0][GW-1:0]    gene_q, gene_d;
  logic [NUM_OUT-1:0][NV-1:0] ref_q, ref_d;

  // next-state: addressed word replaced, others kept
  always_comb begin
    gene_d = gene_q;
    for (int i = 0; i < GLEN; i++) begin
      if (gene_addr == AW'(i)) gene_d[i] = gene_wdata;
    end
  end

  always_comb begin
    ref_d = ref_q;
    for (int o = 0; o < NUM_OUT; o++) begin
      if (ref_sel == OW'(o)) ref_d[o] = ref_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gene_q <= '0;
    else if (gene_we) gene_q <= gene_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_we) ref_q <= ref_d;
  end

  // gene group of the node being computed
  always_comb begin
    node_genes = '0;
    for (int k = 0; k < NUM_NODE; k++) begin
      if (node_sel == NW'(k)) begin
        for (int j = 0; j < 4; j++) node_genes[j] = gene_q[4*k + j];
      end
    end
  end

  genvar go;
  generate
    for (go = 0; go < NUM_OUT; go++) begin : g_out
      assign out_genes[go] = gene_q[4*NUM_NODE + go];
    end
  endgenerate

  assign ref_words = ref_q;

endmodule

// File: rtl/cgp_signal_bank.sv
module cgp_signal_bank #(
  parameter int NUM_IN   = 3,
  parameter int NUM_NODE = 8,
  parameter int NV       = 8,
  parameter int GW       = 4,
  parameter int NW       = 3,
  parameter int NRD      = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NW-1:0]            wr_node,
  input  logic [NV-1:0]            wr_lanes,
  input  logic [NRD-1:0][GW-1:0]   rd_idx,
  output logic [NRD-1:0][NV-1:0]   rd_lanes
);

  logic [NUM_NODE-1:0][NV-1:0] lane_q, lane_d;

  always_comb begin
    lane_d = lane_q;
    for (int k = 0; k < NUM_NODE; k++) begin
      if (wr_node == NW'(k)) lane_d[k] = wr_lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lane_q <= '0;
    else if (wr_en) lane_q <= lane_d;
  end

  // read ports: primary inputs are generated lanes, nodes are stored lanes,
  // any other index reads as all zeros
  always_comb begin
    rd_lanes = '0;
    for (int p = 0; p < NRD; p++) begin
      for (int s = 0; s < NUM_IN; s++) begin
        if (rd_idx[p] == GW'(s)) begin
          for (int v = 0; v < NV; v++) rd_lanes[p][v] = 1'(v >> s);
        end
      end
      for (int k = 0; k < NUM_NODE; k++) begin
        if (rd_idx[p] == GW'(NUM_IN + k)) rd_lanes[p] = lane_q[k];
      end
    end
  end

endmodule

// File: rtl/cgp_eval_ctrl.sv
module cgp_eval_ctrl
  import cgp_pkg::*;
#(
  parameter int NUM_NODE = 8,
  parameter int NW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          launch,
  output logic          node_we,
  output logic [NW-1:0] node_idx,
  output logic          finish
);

  localparam logic [NW-1:0] LAST = NW'(NUM_NODE - 1);

  eval_state_e   state_q, state_d;
  logic [NW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_NODE;
          idx_d   = '0;
        end
      end
      ST_NODE: begin
        if (idx_q == LAST) state_d = ST_FIN;
        else               idx_d   = idx_q + 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign launch   = (state_q == ST_IDLE) && start;
  assign node_we  = (state_q == ST_NODE);
  assign finish   = (state_q == ST_FIN);
  assign node_idx = idx_q;

endmodule

// File: rtl/cgp_chrom_sim.sv
module cgp_chrom_sim
  import cgp_pkg::*;
#(
  parameter int NUM_IN   = 3,
  parameter int NUM_NODE = 8,
  parameter int NUM_OUT  = 2,
  localparam int NV      = 1 << NUM_IN,
  localparam int NSIG    = NUM_IN + NUM_NODE,
  localparam int GW      = $clog2(NSIG + 1),
  localparam int GLEN    = 4 * NUM_NODE + NUM_OUT,
  localparam int AW      = $clog2(GLEN),
  localparam int OW      = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int NW      = (NUM_NODE > 1) ? $clog2(NUM_NODE) : 1,
  localparam int EW      = $clog2(NUM_OUT * NV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gene_we,
  input  logic [AW-1:0] gene_addr,
  input  logic [GW-1:0] gene_wdata,
  input  logic          ref_we,
  input  logic [OW-1:0] ref_sel,
  input  logic [NV-1:0] ref_wdata,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          valid,
  output logic [EW-1:0] err_count
);

  localparam int NRD = 3 + NUM_OUT;
  localparam int LW  = GW + 1;

  logic                       launch, node_we, finish;
  logic [NW-1:0]              node_idx;
  logic [3:0][GW-1:0]         node_genes;
  logic [NUM_OUT-1:0][GW-1:0] out_genes;
  logic [NUM_OUT-1:0][NV-1:0] ref_words;
  logic [NRD-1:0][GW-1:0]     rd_idx;
  logic [NRD-1:0][NV-1:0]     rd_lanes;

  cgp_eval_ctrl #(.NUM_NODE(NUM_NODE), .NW(NW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .launch(launch),
    .node_we(node_we), .node_idx(node_idx), .finish(finish)
  );

  cgp_gene_store #(
    .NUM_NODE(NUM_NODE), .NUM_OUT(NUM_OUT), .NV(NV), .GW(GW),
    .AW(AW), .OW(OW), .NW(NW)
  ) u_genes (
    .clk(clk), .rst_n(rst_n),
    .gene_we(gene_we & ~busy), .gene_addr(gene_addr), .gene_wdata(gene_wdata),
    .ref_we(ref_we & ~busy), .ref_sel(ref_sel), .ref_wdata(ref_wdata),
    .node_sel(node_idx), .node_genes(node_genes), .out_genes(out_genes),
    .ref_words(ref_words)
  );

  // read ports 0..2: operands of current node; 3.. : output genes
  always_comb begin
    rd_idx = '0;
    for (int j = 0; j < 3; j++)       rd_idx[j]     = node_genes[j];
    for (int o = 0; o < NUM_OUT; o++) rd_idx[3 + o] = out_genes[o];
  end

  logic [NV-1:0] node_lanes;

  cgp_signal_bank #(
    .NUM_IN(NUM_IN), .NUM_NODE(NUM_NODE), .NV(NV), .GW(GW), .NW(NW), .NRD(NRD)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(node_we), .wr_node(node_idx),
    .wr_lanes(node_lanes), .rd_idx(rd_idx), .rd_lanes(rd_lanes)
  );

  // ---------------- node evaluation ----------------
  logic [LW-1:0] fwd_limit;
  logic [2:0]    opnd_ok;
  logic          fn_ok, node_bad;
  logic [NV-1:0] op_a, op_b, op_s, fn_res;
  node_fn_e      fn;

  assign fwd_limit = LW'(NUM_IN) + LW'(node_idx);

  always_comb begin
    for (int j = 0; j < 3; j++) opnd_ok[j] = (LW'(node_genes[j]) < fwd_limit);
  end

  assign fn_ok    = (node_genes[3] < GW'(4));
  assign fn       = node_fn_e'(node_genes[3][1:0]);
  assign op_a     = opnd_ok[0] ? rd_lanes[0] : '0;
  assign op_b     = opnd_ok[1] ? rd_lanes[1] : '0;
  assign op_s     = opnd_ok[2] ? rd_lanes[2] : '0;
  assign node_bad = ~(&opnd_ok) | ~fn_ok;

  always_comb begin
    unique case (fn)
      FN_OR:   fn_res = op_a | op_b;
      FN_AND:  fn_res = op_a & op_b;
      FN_XOR:  fn_res = op_a ^ op_b;
      FN_MUX:  fn_res = (op_s & op_b) | (~op_s & op_a);
      default: fn_res = '0;
    endcase
  end

  assign node_lanes = fn_ok ? fn_res : '0;

  // ---------------- output comparison ----------------
  logic          out_bad;
  logic [EW-1:0] miss_cnt;

  always_comb begin
    out_bad  = 1'b0;
    miss_cnt = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      if (out_genes[o] >= GW'(NSIG)) out_bad = 1'b1;
      for (int v = 0; v < NV; v++) begin
        miss_cnt = miss_cnt + EW'(rd_lanes[3 + o][v] ^ ref_words[o][v]);
      end
    end
  end

  // ---------------- result registers ----------------
  logic          bad_q, bad_d;
  logic          done_q, done_d;
  logic          valid_q, valid_d;
  logic [EW-1:0] err_q, err_d;

  always_comb begin
    bad_d   = bad_q;
    valid_d = valid_q;
    err_d   = err_q;
    done_d  = finish;
    if (launch)                bad_d = 1'b0;
    else if (node_we && node_bad) bad_d = 1'b1;
    if (finish) begin
      valid_d = ~(bad_q | out_bad);
      err_d   = miss_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bad_q <= 1'b0;
    else if (launch || node_we) bad_q <= bad_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= '0;
    end else if (finish) begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign done      = done_q;
  assign valid     = valid_q;
  assign err_count = err_q;

endmodule

// File: rtl/cgp_chrom_sim_chk.sv
module cgp_chrom_sim_chk #(
  parameter int NUM_NODE = 8,
  parameter int EW       = 5,
  parameter int MAXERR   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          valid,
  input logic [EW-1:0] err_count
);

  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  // R3: completion pulse lasts a single cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: pulse appears exactly when busy drops
  a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: busy window length
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 16'(NUM_NODE + 1)));

  // R3: start while idle is accepted
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6: count never exceeds outputs times vectors
  a_r6_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_count <= EW'(MAXERR)));

  // R9: results only move with the pulse
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err_count) && $stable(valid)));

endmodule

bind cgp_chrom_sim cgp_chrom_sim_chk #(
  .NUM_NODE(NUM_NODE), .EW(EW), .MAXERR(NUM_OUT * NV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .valid(valid), .err_count(err_count)
);

// File: tb/cgp_chrom_sim_tb.sv
module cgp_chrom_sim_tb;

  localparam int NI   = 3;
  localparam int NN   = 8;
  localparam int NO   = 2;
  localparam int NV   = 1 << NI;
  localparam int NS   = NI + NN;
  localparam int GW   = 4;
  localparam int GLEN = 4 * NN + NO;
  localparam int AW   = 6;
  localparam int OW   = 1;
  localparam int EW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gene_we = 1'b0;
  logic [AW-1:0] gene_addr = '0;
  logic [GW-1:0] gene_wdata = '0;
  logic          ref_we = 1'b0;
  logic [OW-1:0] ref_sel = '0;
  logic [NV-1:0] ref_wdata = '0;
  logic          start = 1'b0;
  logic          busy, done, valid;
  logic [EW-1:0] err_count;

  always #4 clk = ~clk;

  cgp_chrom_sim #(.NUM_IN(NI), .NUM_NODE(NN), .NUM_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .gene_we(gene_we), .gene_addr(gene_addr),
    .gene_wdata(gene_wdata), .ref_we(ref_we), .ref_sel(ref_sel),
    .ref_wdata(ref_wdata), .start(start), .busy(busy), .done(done),
    .valid(valid), .err_count(err_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  bit live     = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int            m_gene[GLEN];
  logic [NV-1:0] m_ref[NO];
  bit            m_busy, m_done, m_valid;
  int            m_cnt, m_err;

  function automatic void m_eval(output int err, output bit ok);
    bit sig[NS];
    int g;
    bit a, b, s, r, y;
    ok  = 1;
    err = 0;
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < NI; i++) sig[i] = ((v >> i) & 1) == 1;
      for (int k = 0; k < NN; k++) begin
        g = m_gene[4*k];   if (g < NI + k) a = sig[g]; else begin a = 0; ok = 0; end
        g = m_gene[4*k+1]; if (g < NI + k) b = sig[g]; else begin b = 0; ok = 0; end
        g = m_gene[4*k+2]; if (g < NI + k) s = sig[g]; else begin s = 0; ok = 0; end
        case (m_gene[4*k+3])
          0: r = a | b;
          1: r = a & b;
          2: r = a ^ b;
          3: r = s ? b : a;
          default: begin r = 0; ok = 0; end
        endcase
        sig[NI + k] = r;
      end
      for (int o = 0; o < NO; o++) begin
        g = m_gene[4*NN + o];
        if (g < NS) y = sig[g]; else begin y = 0; ok = 0; end
        if (y != m_ref[o][v]) err++;
      end
    end
  endfunction

  initial begin
    for (int i = 0; i < GLEN; i++) m_gene[i] = 0;
    for (int o = 0; o < NO; o++) m_ref[o] = '0;
    m_busy = 0; m_done = 0; m_valid = 0; m_cnt = 0; m_err = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_valid = 0; m_err = 0; m_cnt = 0;
    end else if (!m_busy) begin
      m_done = 0;
      if (gene_we && int'(gene_addr) < GLEN) m_gene[gene_addr] = int'(gene_wdata);
      if (ref_we && int'(ref_sel) < NO) m_ref[ref_sel] = ref_wdata;
      if (start) begin m_busy = 1; m_cnt = 0; end
    end else begin
      m_done = 0;
      m_cnt++;
      if (m_cnt == NN + 1) begin
        m_busy = 0;
        m_done = 1;
        m_eval(m_err, m_valid);
      end
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R3", "busy", int'(busy), int'(m_busy));
      chk("R3", "done", int'(done), int'(m_done));
      chk("R6", "err_count", int'(err_count), m_err);
      chk("R8", "valid", int'(valid), int'(m_valid));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put_gene(input int addr, input int val);
    @(negedge clk);
    gene_we = 1'b1; gene_addr = AW'(addr); gene_wdata = GW'(val);
    @(negedge clk);
    gene_we = 1'b0;
  endtask

  task automatic put_ref(input int sel, input logic [NV-1:0] val);
    @(negedge clk);
    ref_we = 1'b1; ref_sel = OW'(sel); ref_wdata = val;
    @(negedge clk);
    ref_we = 1'b0;
  endtask

  task automatic put_node(input int k, input int a, input int b, input int s, input int f);
    put_gene(4*k, a); put_gene(4*k+1, b); put_gene(4*k+2, s); put_gene(4*k+3, f);
  endtask

  task automatic run_eval(input int hold);
    @(negedge clk);
    start = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
    repeat (NN + 3) @(negedge clk);
  endtask

  task automatic load_adder();
    put_node(0, 0, 1, 2, 2);      // XOR in0,in1 (third operand nonzero, ignored)
    put_node(1, 3, 2, 0, 2);      // sum
    put_node(2, 0, 2, 3, 3);      // carry via mux
    for (int k = 3; k < NN; k++) put_node(k, 0, 1, 0, 1);
    put_gene(4*NN, 4);
    put_gene(4*NN + 1, 5);
    put_ref(0, 8'h96);
    put_ref(1, 8'hE8);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "valid in reset", int'(valid), 0);
    chk("R1", "err in reset", int'(err_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    chk("R1", "busy after reset", int'(busy), 0);

    // R4 R5 R6: full adder genome scores zero
    load_adder();
    run_eval(1);
    chk("R6", "adder err", int'(err_count), 0);
    chk("R5", "adder valid", int'(valid), 1);

    // R6: reference with nine wrong bits
    put_ref(0, 8'h97);
    put_ref(1, 8'h17);
    run_eval(1);
    chk("R6", "nine mismatches", int'(err_count), 9);
    chk("R9", "valid held high", int'(valid), 1);

    // R5: mux selects second operand when third is 1 (in2 ? in1 : in0)
    put_ref(0, 8'h96);
    put_ref(1, 8'hCA);
    put_node(2, 0, 1, 2, 3);
    run_eval(1);
    chk("R5", "mux polarity err", int'(err_count), 0);

    // R8: operand naming its own node
    put_gene(8, 5);
    run_eval(1);
    chk("R8", "forward operand valid", int'(valid), 0);
    put_gene(8, 0);

    // R8: undefined operation code on an unused node
    put_gene(4*7 + 3, 7);
    run_eval(1);
    chk("R8", "bad opcode valid", int'(valid), 0);
    put_gene(4*7 + 3, 1);

    // R7: largest legal output gene, then one past it
    put_gene(4*NN + 1, NS - 1);
    run_eval(1);
    chk("R7", "last node output valid", int'(valid), 1);
    put_gene(4*NN + 1, NS);
    run_eval(1);
    chk("R7", "out of range output valid", int'(valid), 0);

    // R2 R3: writes during busy ignored, repeated start ignored
    load_adder();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gene_we = 1'b1; gene_addr = AW'(4*NN); gene_wdata = GW'(0);
    ref_we = 1'b1; ref_sel = '0; ref_wdata = 8'h00;
    @(negedge clk);
    gene_we = 1'b0; ref_we = 1'b0;
    repeat (NN + 3) @(negedge clk);
    run_eval(3);
    chk("R2", "busy writes ignored err", int'(err_count), 0);
    chk("R2", "busy writes ignored valid", int'(valid), 1);

    // random genomes, mostly legal
    for (int it = 0; it < 20; it++) begin
      for (int k = 0; k < NN; k++) begin
        for (int j = 0; j < 3; j++)
          put_gene(4*k + j, ($urandom % 10 == 0) ? $urandom_range(0, 15)
                                                 : $urandom_range(0, NI + k - 1));
        put_gene(4*k + 3, ($urandom % 12 == 0) ? $urandom_range(0, 15)
                                               : $urandom_range(0, 3));
      end
      for (int o = 0; o < NO; o++) begin
        put_gene(4*NN + o, ($urandom % 10 == 0) ? $urandom_range(0, 15)
                                                : $urandom_range(0, NS - 1));
        put_ref(o, NV'($urandom));
      end
      run_eval(1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule